// File: doc/BRIEF.md
# Display Controller Register Bank

This block is the configuration register file of a display controller. A host reaches it through a word-only port: each cycle with `req` high performs one access, a write when `we` is high and a read otherwise. The bank holds global control and configuration, colour keys, timing words, the two panel sizes and the graphics-layer setup. It also holds the interrupt status and enable words that drive one level-sensitive interrupt line.

Event pulses from the display pipeline set the sticky interrupt status bits. Software clears them by writing ones. Width and height fields are kept internally as the count (field plus one), and they read back in the field form. A soft reset, requested through the system-config word, returns every register to its reset value. An unused video-overlay window reads as zero and ignores writes. Any other address outside the map is refused and flagged.

Top module: `dispc_regbank`

## Requirements
- R1: `irq` is high exactly when the interrupt status word ANDed with the interrupt enable word (offset 0x0C) is nonzero. It follows any status or enable change one cycle after the edge that caused it.
- R2: Interrupt status (offset 0x08) bits are set by `evt` pulses and stay set. A write clears each bit written as 1 and leaves the rest. When an event and a clear hit the same bit in the same cycle, the event wins. The enable word keeps only the low 16 bits.
- R3: A write to system-config (offset 0x00) with bit 1 set returns every register to its reset value, and an event in that cycle is dropped. System-config then holds the written value AND 0x301B.
- R4: Control (offset 0x10) keeps value AND 0x07FF9FFF. Its bit 0 drives `lcd_en` and its bit 1 drives `dig_en`.
- R5: The size words for digital output (0x44), LCD (0x48) and the graphics layer (0x58) take width in bits 10:0 and height in bits 26:16, each stored as field plus one. Reads return the written fields with all other bits zero, so a 1x1 size reads 0.
- R6: After reset, capability (offset 0x18) reads 0x161 and keeps value AND 0x3FF when written. Row increment (0x68) and pixel increment (0x6C) read 1. Control and interrupt status read 0.
- R7: System status (0x04) always reads 1, line status (0x2C) always reads 0x7FF, and FIFO status (0x64) always reads 256. Writes to these addresses change nothing.
- R8: The following masks apply. Config (0x14) keeps 14 bits. Colour and key words (0x1C to 0x28) keep 24 bits. Line number (0x30) keeps 11 bits. Horizontal and vertical timing (0x34, 0x38) keep value AND 0x0FF0FF3F. Polarity (0x3C) keeps 18 bits. Divisor (0x40) keeps value AND 0x00FF00FF.
- R9: The layer position word (0x54) keeps two 11-bit fields at bits 10:0 and 26:16 with no offset. Layer attributes (0x5C) keep 11 bits. The FIFO threshold (0x60) keeps value AND 0x01FF01FF.
- R10: The overlay window from 0x080 to 0x0FF reads as zero, ignores writes and raises no error.
- R11: An access to 0x078, to 0x07C or to 0x100 and above reads zero and changes no state. It raises `err` for exactly the one cycle after the access.
- R12: Writes take effect on the clock edge of the access. Read data appears on `rdata` on the edge of the access and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access valid this cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W (10) | Byte address; bits 1:0 ignored |
| wdata | input | 32 | Write data |
| evt | input | IRQ_W (16) | Interrupt event pulses, one per status bit |
| rdata | output | 32 | Registered read data |
| err | output | 1 | One-cycle pulse after an unmapped access |
| irq | output | 1 | Level interrupt |
| lcd_en | output | 1 | LCD output enable (control bit 0) |
| dig_en | output | 1 | Digital output enable (control bit 1) |

## Verification
The hardest case to reach is a collision on the status word: an event and a clear, or an event and a soft reset, must land on the same edge. The bench holds `evt` and the register write in the same low clock phase so that both are sampled together. It then reads the status word back to see which side won. The plus-one size storage is seen only through its reset value and its readback, so sizes are checked both after reset and after writes of all-ones.

// File: rtl/dispc_regbank.sv
module dispc_regbank #(
  parameter int ADDR_W = 10,
  parameter int IRQ_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [IRQ_W-1:0]  evt,
  output logic [31:0]       rdata,
  output logic              err,
  output logic              irq,
  output logic              lcd_en,
  output logic              dig_en
);

  typedef logic [ADDR_W-1:0] adr_t;
  localparam adr_t A_SYSCFG = adr_t'('h000);
  localparam adr_t A_SYSST  = adr_t'('h004);
  localparam adr_t A_ISTAT  = adr_t'('h008);
  localparam adr_t A_IEN    = adr_t'('h00C);
  localparam adr_t A_CTRL   = adr_t'('h010);
  localparam adr_t A_CFG    = adr_t'('h014);
  localparam adr_t A_CAP    = adr_t'('h018);
  localparam adr_t A_BG0    = adr_t'('h01C);
  localparam adr_t A_BG1    = adr_t'('h020);
  localparam adr_t A_KEY0   = adr_t'('h024);
  localparam adr_t A_KEY1   = adr_t'('h028);
  localparam adr_t A_LNST   = adr_t'('h02C);
  localparam adr_t A_LNUM   = adr_t'('h030);
  localparam adr_t A_TIMH   = adr_t'('h034);
  localparam adr_t A_TIMV   = adr_t'('h038);
  localparam adr_t A_POL    = adr_t'('h03C);
  localparam adr_t A_DIV    = adr_t'('h040);
  localparam adr_t A_SZDIG  = adr_t'('h044);
  localparam adr_t A_SZLCD  = adr_t'('h048);
  localparam adr_t A_BASE0  = adr_t'('h04C);
  localparam adr_t A_BASE1  = adr_t'('h050);
  localparam adr_t A_POS    = adr_t'('h054);
  localparam adr_t A_SZGFX  = adr_t'('h058);
  localparam adr_t A_ATTR   = adr_t'('h05C);
  localparam adr_t A_THR    = adr_t'('h060);
  localparam adr_t A_FIFOST = adr_t'('h064);
  localparam adr_t A_ROWINC = adr_t'('h068);
  localparam adr_t A_PIXINC = adr_t'('h06C);
  localparam adr_t A_SKIP   = adr_t'('h070);
  localparam adr_t A_TBASE  = adr_t'('h074);
  localparam adr_t A_OVL_LO = adr_t'('h080);
  localparam adr_t A_OVL_HI = adr_t'('h0FC);

  typedef struct packed {
    logic [31:0]      ctrl, cfg, cap, bg0, bg1, key0, key1;
    logic [10:0]      line;
    logic [31:0]      tim_h, tim_v, pol, div;
    logic [11:0]      dig_nx, dig_ny, lcd_nx, lcd_ny, gfx_nx, gfx_ny;
    logic [10:0]      posx, posy;
    logic [31:0]      base0, base1, tbase, attr, thr, rowinc, pixinc, skip;
    logic [IRQ_W-1:0] stat, en;
  } regs_t;

  localparam regs_t RST = '{cap: 32'h161,
                            dig_nx: 12'd1, dig_ny: 12'd1,
                            lcd_nx: 12'd1, lcd_ny: 12'd1,
                            gfx_nx: 12'd1, gfx_ny: 12'd1,
                            rowinc: 32'd1, pixinc: 32'd1,
                            default: 0};

  regs_t       r;
  logic [31:0] syscfg;
  logic [31:0] rd_val;
  logic        mapped, in_ovl;
  adr_t        wa;

  assign wa     = {addr[ADDR_W-1:2], 2'b00};
  assign in_ovl = (wa >= A_OVL_LO) && (wa <= A_OVL_HI);

  wire wr   = req && we;
  wire srst = wr && (wa == A_SYSCFG) && wdata[1];
  wire clr  = wr && (wa == A_ISTAT);

  function automatic logic [31:0] sz_rd(input logic [11:0] nx, input logic [11:0] ny);
    logic [11:0] a, b;
    a = nx - 12'd1;
    b = ny - 12'd1;
    return {5'b0, b[10:0], 5'b0, a[10:0]};
  endfunction

  function automatic logic [11:0] sz_wr(input logic [10:0] f);
    return {1'b0, f} + 12'd1;
  endfunction

  always_comb begin
    mapped = 1'b1;
    rd_val = '0;
    case (wa)
      A_SYSCFG: rd_val = syscfg;
      A_SYSST:  rd_val = 32'd1;
      A_ISTAT:  rd_val = 32'(r.stat);
      A_IEN:    rd_val = 32'(r.en);
      A_CTRL:   rd_val = r.ctrl;
      A_CFG:    rd_val = r.cfg;
      A_CAP:    rd_val = r.cap;
      A_BG0:    rd_val = r.bg0;
      A_BG1:    rd_val = r.bg1;
      A_KEY0:   rd_val = r.key0;
      A_KEY1:   rd_val = r.key1;
      A_LNST:   rd_val = 32'h7FF;
      A_LNUM:   rd_val = {21'b0, r.line};
      A_TIMH:   rd_val = r.tim_h;
      A_TIMV:   rd_val = r.tim_v;
      A_POL:    rd_val = r.pol;
      A_DIV:    rd_val = r.div;
      A_SZDIG:  rd_val = sz_rd(r.dig_nx, r.dig_ny);
      A_SZLCD:  rd_val = sz_rd(r.lcd_nx, r.lcd_ny);
      A_BASE0:  rd_val = r.base0;
      A_BASE1:  rd_val = r.base1;
      A_POS:    rd_val = {5'b0, r.posy, 5'b0, r.posx};
      A_SZGFX:  rd_val = sz_rd(r.gfx_nx, r.gfx_ny);
      A_ATTR:   rd_val = r.attr;
      A_THR:    rd_val = r.thr;
      A_FIFOST: rd_val = 32'd256;
      A_ROWINC: rd_val = r.rowinc;
      A_PIXINC: rd_val = r.pixinc;
      A_SKIP:   rd_val = r.skip;
      A_TBASE:  rd_val = r.tbase;
      default:  mapped = in_ovl;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r      <= RST;
      syscfg <= '0;
    end else if (srst) begin
      r      <= RST;
      syscfg <= wdata & 32'h301B;
    end else begin
      r.stat <= (r.stat & ~(clr ? wdata[IRQ_W-1:0] : '0)) | evt;
      if (wr) begin
        case (wa)
          A_SYSCFG: syscfg  <= wdata & 32'h301B;
          A_IEN:    r.en    <= wdata[IRQ_W-1:0];
          A_CTRL:   r.ctrl  <= wdata & 32'h07FF9FFF;
          A_CFG:    r.cfg   <= wdata & 32'h3FFF;
          A_CAP:    r.cap   <= wdata & 32'h3FF;
          A_BG0:    r.bg0   <= wdata & 32'hFFFFFF;
          A_BG1:    r.bg1   <= wdata & 32'hFFFFFF;
          A_KEY0:   r.key0  <= wdata & 32'hFFFFFF;
          A_KEY1:   r.key1  <= wdata & 32'hFFFFFF;
          A_LNUM:   r.line  <= wdata[10:0];
          A_TIMH:   r.tim_h <= wdata & 32'h0FF0FF3F;
          A_TIMV:   r.tim_v <= wdata & 32'h0FF0FF3F;
          A_POL:    r.pol   <= wdata & 32'h3FFFF;
          A_DIV:    r.div   <= wdata & 32'h00FF00FF;
          A_SZDIG: begin r.dig_nx <= sz_wr(wdata[10:0]); r.dig_ny <= sz_wr(wdata[26:16]); end
          A_SZLCD: begin r.lcd_nx <= sz_wr(wdata[10:0]); r.lcd_ny <= sz_wr(wdata[26:16]); end
          A_SZGFX: begin r.gfx_nx <= sz_wr(wdata[10:0]); r.gfx_ny <= sz_wr(wdata[26:16]); end
          A_POS:   begin r.posx <= wdata[10:0]; r.posy <= wdata[26:16]; end
          A_BASE0:  r.base0  <= wdata;
          A_BASE1:  r.base1  <= wdata;
          A_ATTR:   r.attr   <= wdata & 32'h7FF;
          A_THR:    r.thr    <= wdata & 32'h01FF01FF;
          A_ROWINC: r.rowinc <= wdata;
          A_PIXINC: r.pixinc <= wdata;
          A_SKIP:   r.skip   <= wdata;
          A_TBASE:  r.tbase  <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
      err   <= 1'b0;
    end else begin
      err <= req && !mapped;
      if (req && !we) rdata <= mapped ? rd_val : 32'd0;
    end
  end

  assign irq    = |(r.stat & r.en);
  assign lcd_en = r.ctrl[0];
  assign dig_en = r.ctrl[1];

  // R1: clearing the enable word silences the line on the next cycle
  a_r1_irq_off: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wa == A_IEN && wdata[IRQ_W-1:0] == '0) |=> !irq);

  // R2: bits written as one are clear afterwards when no event arrived
  a_r2_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && evt == '0) |=> ((r.stat & $past(wdata[IRQ_W-1:0])) == '0));

  // R3: soft reset leaves control and status at zero
  a_r3_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (r.ctrl == '0 && r.stat == '0 && !irq));

  // R4: output enables move only through control writes or reset
  a_r4_en_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && (wa == A_CTRL || wa == A_SYSCFG)) |=> ($stable(lcd_en) && $stable(dig_en)));

  // R10: overlay window reads zero
  a_r10_ovl_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we && in_ovl) |=> (rdata == '0 && !err));

  // R11: error pulse after an unmapped access and never without an access
  a_r11_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !mapped) |=> err);
  a_r11_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !err);

endmodule

// File: tb/dispc_regbank_tb.sv
module dispc_regbank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [15:0] evt = '0;
  logic [31:0] rdata;
  logic        err, irq, lcd_en, dig_en;

  int n_vec = 0, n_bad = 0;
  logic last_err;
  logic [31:0] d;
  bit done = 0;

  always #5 clk = ~clk;

  dispc_regbank u_dut (.clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
    .wdata(wdata), .evt(evt), .rdata(rdata), .err(err), .irq(irq),
    .lcd_en(lcd_en), .dig_en(dig_en));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] v);
    req = 1; we = 1; addr = a; wdata = v;
    @(negedge clk);
    last_err = err;
    req = 0; we = 0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] v);
    req = 1; we = 0; addr = a;
    @(negedge clk);
    v = rdata; last_err = err;
    req = 0;
  endtask

  task automatic pulse(input logic [15:0] v);
    evt = v;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic t_reset;
    rd('h018, d); chk("R6 cap reset", d, 32'h161);
    rd('h048, d); chk("R5 lcd size reset", d, 32'h0);
    rd('h058, d); chk("R5 gfx size reset", d, 32'h0);
    rd('h068, d); chk("R6 row inc reset", d, 32'd1);
    rd('h06C, d); chk("R6 pix inc reset", d, 32'd1);
    rd('h010, d); chk("R6 ctrl reset", d, 32'h0);
    rd('h008, d); chk("R6 status reset", d, 32'h0);
    chk("R6 irq reset", {31'b0, irq}, 32'h0);
    chk("R4 enables reset", {30'b0, dig_en, lcd_en}, 32'h0);
  endtask

  task automatic t_irq;
    wr('h00C, 32'hFFFF_FFFF);
    rd('h00C, d); chk("R2 enable 16 bits", d, 32'hFFFF);
    wr('h00C, 32'h0003);
    chk("R1 no status no irq", {31'b0, irq}, 0);
    pulse(16'h0001);
    chk("R1 irq after event", {31'b0, irq}, 1);
    pulse(16'h0010);
    rd('h008, d); chk("R2 sticky status", d, 32'h11);
    wr('h008, 32'h0001);
    chk("R1 irq after clear", {31'b0, irq}, 0);
    rd('h008, d); chk("R2 w1c keeps others", d, 32'h10);
    wr('h00C, 32'h0010);
    chk("R1 irq after enable", {31'b0, irq}, 1);
    wr('h00C, 32'h0);
    chk("R1 irq after disable", {31'b0, irq}, 0);
    evt = 16'h0004; req = 1; we = 1; addr = 'h008; wdata = 32'h0014;
    @(negedge clk);
    evt = '0; req = 0; we = 0;
    rd('h008, d); chk("R2 event beats clear", d, 32'h4);
    wr('h008, 32'hFFFF);
    rd('h008, d); chk("R2 clear all", d, 32'h0);
  endtask

  task automatic t_ctrl;
    wr('h010, 32'hFFFF_FFFF);
    rd('h010, d); chk("R4 ctrl mask", d, 32'h07FF9FFF);
    chk("R4 both enables", {30'b0, dig_en, lcd_en}, 32'h3);
    wr('h010, 32'h2);
    chk("R4 dig only", {30'b0, dig_en, lcd_en}, 32'h2);
    wr('h010, 32'h1);
    chk("R4 lcd only", {30'b0, dig_en, lcd_en}, 32'h1);
  endtask

  task automatic t_sizes;
    wr('h044, 32'hFFFF_FFFF);
    rd('h044, d); chk("R5 dig size max", d, 32'h07FF07FF);
    wr('h048, 32'h00EF_013F);
    rd('h048, d); chk("R5 lcd size", d, 32'h00EF013F);
    wr('h058, 32'hF801_F802);
    rd('h058, d); chk("R5 gfx size fields", d, 32'h00010002);
    wr('h054, 32'hFFFF_FFFF);
    rd('h054, d); chk("R9 position", d, 32'h07FF07FF);
  endtask

  task automatic t_masks;
    wr('h014, 32'hFFFF_FFFF); rd('h014, d); chk("R8 cfg", d, 32'h3FFF);
    wr('h018, 32'hFFFF_FFFF); rd('h018, d); chk("R6 cap mask", d, 32'h3FF);
    wr('h01C, 32'hFFFF_FFFF); rd('h01C, d); chk("R8 bg0", d, 32'hFFFFFF);
    wr('h028, 32'hABCD_EF12); rd('h028, d); chk("R8 key1", d, 32'hCDEF12);
    wr('h030, 32'hFFFF_FFFF); rd('h030, d); chk("R8 line number", d, 32'h7FF);
    wr('h034, 32'hFFFF_FFFF); rd('h034, d); chk("R8 timing h", d, 32'h0FF0FF3F);
    wr('h038, 32'hFFFF_FFFF); rd('h038, d); chk("R8 timing v", d, 32'h0FF0FF3F);
    wr('h03C, 32'hFFFF_FFFF); rd('h03C, d); chk("R8 polarity", d, 32'h3FFFF);
    wr('h040, 32'hFFFF_FFFF); rd('h040, d); chk("R8 divisor", d, 32'h00FF00FF);
    wr('h05C, 32'hFFFF_FFFF); rd('h05C, d); chk("R9 attributes", d, 32'h7FF);
    wr('h060, 32'hFFFF_FFFF); rd('h060, d); chk("R9 threshold", d, 32'h01FF01FF);
    wr('h04C, 32'h1234_5678); rd('h04C, d); chk("R12 base write", d, 32'h12345678);
  endtask

  task automatic t_const;
    wr('h004, 32'h0); rd('h004, d); chk("R7 sys status", d, 32'd1);
    wr('h02C, 32'h0); rd('h02C, d); chk("R7 line status", d, 32'h7FF);
    wr('h064, 32'h0); rd('h064, d); chk("R7 fifo status", d, 32'd256);
  endtask

  task automatic t_ovl_unmapped;
    wr('h080, 32'hFFFF_FFFF); chk("R10 no err write", {31'b0, last_err}, 0);
    rd('h080, d); chk("R10 reads zero", d, 0);
    chk("R10 no err read", {31'b0, last_err}, 0);
    rd('h0FC, d); chk("R10 top reads zero", d, 0);
    rd('h010, d);
    wr('h200, 32'h0);
    chk("R11 err on write", {31'b0, last_err}, 1);
    rd('h078, d); chk("R11 gap reads zero", d, 0);
    chk("R11 err on read", {31'b0, last_err}, 1);
    @(negedge clk);
    chk("R11 err one cycle", {31'b0, err}, 0);
    rd('h010, d); chk("R11 ctrl untouched", d, 32'h1);
    chk("R11 no err mapped", {31'b0, last_err}, 0);
  endtask

  task automatic t_soft_reset;
    wr('h00C, 32'h0001);
    pulse(16'h0001);
    chk("R1 irq before reset", {31'b0, irq}, 1);
    evt = 16'h0002; req = 1; we = 1; addr = 'h000; wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    evt = '0; req = 0; we = 0;
    rd('h000, d); chk("R3 syscfg mask", d, 32'h301B);
    rd('h008, d); chk("R3 event dropped", d, 0);
    rd('h010, d); chk("R3 ctrl reset", d, 0);
    rd('h018, d); chk("R3 cap reset", d, 32'h161);
    rd('h044, d); chk("R3 size reset", d, 0);
    rd('h00C, d); chk("R3 enable reset", d, 0);
    chk("R3 irq low", {31'b0, irq}, 0);
    wr('h000, 32'h1);
    rd('h000, d); chk("R3 plain write", d, 32'h1);
    rd('h034, d); chk("R3 no reset without bit1", d, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_irq();
    t_ctrl();
    t_sizes();
    t_masks();
    t_const();
    t_ovl_unmapped();
    t_soft_reset();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule